// File: doc/BRIEF.md
# Paired Three-Compare PWM Generator

The block drives six PWM outputs arranged as three high-side/low-side pairs. Each pair owns a 16-bit period counter, a period-length value and three compare values. One compare value sets where the high-side output rises and another sets where it falls. The low-side output rises when the count reaches the period length. It falls at the third compare value, or on the same clock edge that its high-side partner falls, so the low side can never outlast its partner's falling edge. A shared prescaler feeds all three counters. It advances them once every 2, 4, 8, 16, 32, 64, 128 or 256 input clocks.

Software uses a flat write port with a combinational read-back. Field f of pair p sits at address 4p+f, where f=0 is high rise, f=1 is high fall, f=2 is low fall and f=3 is period length. The control word is at address 12 and the interrupt acknowledge is at address 13. The control word bits are: [0] run, [1] bridge mode, [2] bridge direction, [5:3] prescale select. The word resets to 0x0012, which selects bridge mode, the stopped state and divide-by-8, so every output is low. In bridge mode, outputs 0 and 1 are the high and low switch of leg A, and outputs 2 and 3 are the high and low switch of leg B. Only one diagonal follows the pair-0 high-side waveform.

Top module: `pwm3_gen`

## Requirements
- R1: After reset the control word reads 0x0012, every compare and length field reads 0, all six outputs are low and the interrupt is low.
- R2: While running, the counters advance once every 2^(s+1) input clocks, where s is control bits [5:3]. The first advance comes 2^(s+1) clocks after the write that sets run.
- R3: A pair's counter counts 0,1,...,L and returns to 0 on the advance after it equals its period length L, so one period is L+1 advances.
- R4: On an advance where the count equals the rise value, the high-side output goes high. Where it equals the fall value, it goes low, and the fall wins when both match.
- R5: On an advance where the count equals L, the low-side output goes high. Where it equals the low-fall value, it goes low, and the fall wins.
- R6: The low-side output goes low on the same edge that its high-side partner goes low.
- R7: Field writes are read back at once but are used only from the advance that returns the counter to 0 (or at once while stopped).
- R8: The interrupt is set when any pair returns to 0 and stays set until a write to address 13. A set and a clear on the same edge leave it set.
- R9: With control bit 1 set, direction bit 2 = 0 puts the pair-0 high waveform on outputs 0 and 3, and direction = 1 puts it on outputs 1 and 2. All other outputs are low. With bit 1 clear, output 2p is pair p high and output 2p+1 is pair p low.
- R10: While control bit 0 is clear, the counters are held at 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read-back data for reg_addr |
| pwm_out | output | 6 | PWM outputs |
| irq | output | 1 | Sticky period interrupt |

## Verification
The interrupt acknowledge and a period wrap can land on the same clock edge. The bench predicts from its own counter model when the next wrap will happen, issues the acknowledge write on exactly that edge, and expects the flag to remain set. A field write can also meet a wrap on the same edge. Sweeps that rewrite fields while running show whether the old or the new value governs the next period.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int unsigned FIELDS    = 4;
  localparam int unsigned IDX_RISE  = 0;
  localparam int unsigned IDX_FALL  = 1;
  localparam int unsigned IDX_LFALL = 2;
  localparam int unsigned IDX_LEN   = 3;
  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_HB     = 1;
  localparam int unsigned CB_DIR    = 2;
  localparam int unsigned CB_SEL    = 3;
  localparam logic [15:0] CTRL_RST  = 16'h0012;
endpackage

// File: rtl/pwm3_prescale.sv
module pwm3_prescale #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned DIV_W = 1 << SEL_W;

  logic [DIV_W-1:0] div_q, div_d, mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i <= int'(sel));
  end

  assign tick = en && ((div_q & mask) == mask);

  always_comb begin
    div_d = div_q;
    if (!en) div_d = '0;
    else     div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R2: a tick never repeats on the next cycle (divide is at least 2)
  a_r2_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pwm3_pair.sv
module pwm3_pair
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          tick,
  input  logic                          wr_en,
  input  logic [1:0]                    wr_sel,
  input  logic [CNT_W-1:0]              wr_data,
  output logic [FIELDS-1:0][CNT_W-1:0]  pend,
  output logic                          hi,
  output logic                          lo,
  output logic                          wrap
);
  logic [FIELDS-1:0][CNT_W-1:0] pend_q, pend_d, act_q, act_d;
  logic [CNT_W-1:0]             cnt_q, cnt_d;
  logic                         hi_q, hi_d, lo_q, lo_d;
  logic                         at_len;

  assign at_len = (cnt_q == act_q[IDX_LEN]);
  assign wrap   = en && tick && at_len;
  assign pend   = pend_q;
  assign hi     = hi_q;
  assign lo     = lo_q;

  always_comb begin
    pend_d = pend_q;
    if (wr_en) pend_d[wr_sel] = wr_data;
  end

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    if (!en) begin
      act_d = pend_q;
      cnt_d = '0;
      hi_d  = 1'b0;
      lo_d  = 1'b0;
    end else if (tick) begin
      if (cnt_q == act_q[IDX_RISE]) hi_d = 1'b1;
      if (cnt_q == act_q[IDX_FALL]) hi_d = 1'b0;
      if (at_len)                   lo_d = 1'b1;
      if ((cnt_q == act_q[IDX_LFALL]) || (hi_q && !hi_d)) lo_d = 1'b0;
      if (at_len) begin
        cnt_d = '0;
        act_d = pend_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      cnt_q  <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  // R6: low side is never high just after its partner fell
  a_r6_low_drops_with_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hi_q) |-> !lo_q);
  // R3: count stays within the active period
  a_r3_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= act_q[IDX_LEN]));
  // R7: active settings change only at a wrap or while stopped
  a_r7_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(tick && at_len)) |=> $stable(act_q));
  // R10: stopped means counter zero and outputs low
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && !hi_q && !lo_q));
endmodule

// File: rtl/pwm3_outmux.sv
module pwm3_outmux #(
  parameter int unsigned N_PAIRS = 3
) (
  input  logic                 hb_mode,
  input  logic                 dir,
  input  logic [N_PAIRS-1:0]   hi,
  input  logic [N_PAIRS-1:0]   lo,
  output logic [2*N_PAIRS-1:0] out
);
  logic [2*N_PAIRS-1:0] std_out;

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_std
    assign std_out[2*p]   = hi[p];
    assign std_out[2*p+1] = lo[p];
  end

  always_comb begin
    out = std_out;
    if (hb_mode) begin
      out    = '0;
      out[0] = hi[0] && !dir;
      out[3] = hi[0] && !dir;
      out[1] = hi[0] && dir;
      out[2] = hi[0] && dir;
    end
  end
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned N_PAIRS = 3,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic [CNT_W-1:0]     reg_rdata,
  output logic [2*N_PAIRS-1:0] pwm_out,
  output logic                 irq
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(4 * N_PAIRS);
  localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(4 * N_PAIRS + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_i;
  logic [CNT_W-1:0] ctrl_q, ctrl_d;
  logic             irq_q, irq_d;
  logic             tick, clr_hit;
  logic [N_PAIRS-1:0] hi_v, lo_v, wrap_v;
  logic [N_PAIRS-1:0][FIELDS-1:0][CNT_W-1:0] pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign clr_hit = reg_we && (reg_addr == ADDR_CLR);

  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_we && reg_addr == ADDR_CTRL) ctrl_d = reg_wdata;
  end

  always_comb begin
    irq_d = irq_q;
    if (clr_hit)    irq_d = 1'b0;
    if (|wrap_v)    irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= CNT_W'(CTRL_RST);
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= irq_d;
    end
  end
  assign irq = irq_q;

  pwm3_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_i),
    .en   (ctrl_q[CB_RUN]),
    .sel  (ctrl_q[CB_SEL +: SEL_W]),
    .tick (tick)
  );

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    pwm3_pair #(.CNT_W(CNT_W)) u_pair (
      .clk    (clk),
      .rst_n  (rst_i),
      .en     (ctrl_q[CB_RUN]),
      .tick   (tick),
      .wr_en  (reg_we && (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(p))),
      .wr_sel (reg_addr[1:0]),
      .wr_data(reg_wdata),
      .pend   (pend_v[p]),
      .hi     (hi_v[p]),
      .lo     (lo_v[p]),
      .wrap   (wrap_v[p])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) reg_rdata = ctrl_q;
    for (int p = 0; p < N_PAIRS; p++) begin
      if (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(p)) reg_rdata = pend_v[p][reg_addr[1:0]];
    end
  end

  pwm3_outmux #(.N_PAIRS(N_PAIRS)) u_mux (
    .hb_mode(ctrl_q[CB_HB]),
    .dir    (ctrl_q[CB_DIR]),
    .hi     (hi_v),
    .lo     (lo_v),
    .out    (pwm_out)
  );

  // R8: a wrap always leaves the flag set
  a_r8_set_on_wrap: assert property (@(posedge clk) disable iff (!rst_i)
    (|wrap_v) |=> irq);
  // R8: the flag holds until acknowledged
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    (irq && !clr_hit) |=> irq);
  // R9: no leg drives both switches in bridge mode
  a_r9_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_i)
    ctrl_q[CB_HB] |-> (!(pwm_out[0] && pwm_out[1]) && !(pwm_out[2] && pwm_out[3])));
endmodule

// File: tb/pwm3_gen_bench.sv
module pwm3_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [5:0]  pwm_out;
  logic        irq;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  logic [15:0] m_pend[3][4];
  logic [15:0] m_act[3][4];
  logic [15:0] m_cnt[3];
  bit          m_hi[3];
  bit          m_lo[3];
  bit          m_irq;
  logic [15:0] m_ctrl;
  int          m_div;

  always #10 clk = ~clk;

  pwm3_gen u_pwm3_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
  );

  function automatic int div_n();
    return 2 << m_ctrl[5:3];
  endfunction

  function automatic bit next_wrap();
    bit w = 0;
    if (m_ctrl[0] && (m_div % div_n()) == div_n() - 1)
      for (int p = 0; p < 3; p++) if (m_cnt[p] == m_act[p][3]) w = 1;
    return w;
  endfunction

  function automatic logic [5:0] exp_out();
    logic [5:0] v = '0;
    if (m_ctrl[1]) begin
      if (!m_ctrl[2]) begin v[0] = m_hi[0]; v[3] = m_hi[0]; end
      else            begin v[1] = m_hi[0]; v[2] = m_hi[0]; end
    end else begin
      for (int p = 0; p < 3; p++) begin v[2*p] = m_hi[p]; v[2*p+1] = m_lo[p]; end
    end
    return v;
  endfunction

  task automatic model_edge(input bit we, input logic [3:0] a, input logic [15:0] d);
    bit run = m_ctrl[0];
    int n = div_n();
    bit tk = run && ((m_div % n) == n - 1);
    bit any_wrap = 0;
    for (int p = 0; p < 3; p++) begin
      if (!run) begin
        for (int f = 0; f < 4; f++) m_act[p][f] = m_pend[p][f];
        m_cnt[p] = 0; m_hi[p] = 0; m_lo[p] = 0;
      end else if (tk) begin
        bit nh = m_hi[p];
        bit nl = m_lo[p];
        bit w = (m_cnt[p] == m_act[p][3]);
        if (m_cnt[p] == m_act[p][0]) nh = 1;
        if (m_cnt[p] == m_act[p][1]) nh = 0;
        if (w) nl = 1;
        if (m_cnt[p] == m_act[p][2] || (m_hi[p] && !nh)) nl = 0;
        m_hi[p] = nh; m_lo[p] = nl;
        if (w) begin
          any_wrap = 1; m_cnt[p] = 0;
          for (int f = 0; f < 4; f++) m_act[p][f] = m_pend[p][f];
        end else m_cnt[p] = m_cnt[p] + 1;
      end
    end
    m_div = run ? (m_div + 1) % 256 : 0;
    if (we && a == 4'd13) m_irq = 0;
    if (any_wrap) m_irq = 1;
    if (we && a == 4'd12) m_ctrl = d;
    if (we && a[3:2] != 2'd3) m_pend[a[3:2]][a[1:0]] = d;
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic step(input bit we = 0, input logic [3:0] a = 0, input logic [15:0] d = 0);
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_edge(we, a, d);
    @(negedge clk);
    reg_we = 0;
    check(pwm_out === exp_out(), "outputs", int'(pwm_out), int'(exp_out()));
    check(irq === m_irq, "irq", int'(irq), int'(m_irq));
  endtask

  task automatic readback(input logic [3:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    check(reg_rdata === exp, "readback", int'(reg_rdata), int'(exp));
  endtask

  task automatic wr_pair(input int p, input logic [15:0] r, input logic [15:0] f,
                         input logic [15:0] lf, input logic [15:0] len);
    step(1, 4'(4*p+0), r); step(1, 4'(4*p+1), f);
    step(1, 4'(4*p+2), lf); step(1, 4'(4*p+3), len);
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < 3; p++) begin
      m_cnt[p] = 0; m_hi[p] = 0; m_lo[p] = 0;
      for (int f = 0; f < 4; f++) begin m_pend[p][f] = 0; m_act[p][f] = 0; end
    end
    m_irq = 0; m_ctrl = 16'h0012; m_div = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1";
    run_n(4);
    readback(4'd12, 16'h0012);
    for (int a = 0; a < 12; a++) readback(4'(a), 16'h0000);

    cur_req = "R10";
    wr_pair(0, 2, 6, 1, 9);
    run_n(30);

    cur_req = "R4";
    wr_pair(1, 0, 3, 5, 7);
    wr_pair(2, 3, 3, 2, 5);
    readback(4'd7, 16'd7);
    step(1, 4'd12, 16'h0001);
    run_n(300);

    cur_req = "R6";
    step(1, 4'd12, 16'h0000);
    wr_pair(2, 1, 4, 6, 8);
    step(1, 4'd12, 16'h0009);
    run_n(400);

    cur_req = "R2";
    for (int s = 0; s < 8; s++) begin
      step(1, 4'd12, 16'h0000);
      wr_pair(0, 1, 2, 0, 3);
      step(1, 4'd12, 16'(1 | (s << 3)));
      run_n(3 * 4 * (2 << s) + 5);
    end

    cur_req = "R3";
    step(1, 4'd12, 16'h0000);
    wr_pair(0, 0, 0, 0, 0);
    step(1, 4'd12, 16'h0001);
    run_n(40);

    cur_req = "R7";
    step(1, 4'd12, 16'h0000);
    wr_pair(0, 1, 5, 3, 11);
    step(1, 4'd12, 16'h0001);
    run_n(9);
    step(1, 4'd1, 16'd8);
    readback(4'd1, 16'd8);
    step(1, 4'd3, 16'd4);
    run_n(120);
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 100 && !next_wrap(); i++) step();
      step(1, 4'd3, 16'(3 + k));
      run_n(17);
    end

    cur_req = "R8";
    run_n(5);
    step(1, 4'd13, 16'h0);
    check(irq === m_irq, "clear", int'(irq), int'(m_irq));
    for (int i = 0; i < 100 && !next_wrap(); i++) step();
    step(1, 4'd13, 16'h0);
    check(irq === 1'b1, "clear at wrap", int'(irq), 1);
    run_n(3);
    for (int i = 0; i < 100 && next_wrap(); i++) step();
    step(1, 4'd13, 16'h0);
    check(irq === m_irq, "clear off wrap", int'(irq), int'(m_irq));

    cur_req = "R9";
    step(1, 4'd12, 16'h0000);
    wr_pair(0, 2, 7, 1, 9);
    step(1, 4'd12, 16'h0003);
    run_n(100);
    step(1, 4'd12, 16'h0007);
    run_n(100);

    cur_req = "R10";
    step(1, 4'd12, 16'h0000);
    run_n(20);
    step(1, 4'd12, 16'h0001);
    run_n(60);

    cur_req = "R5";
    step(1, 4'd12, 16'h0000);
    wr_pair(1, 9, 9, 2, 6);
    wr_pair(2, 5, 6, 4, 4);
    step(1, 4'd12, 16'h0009);
    run_n(300);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule